// File: doc/BRIEF.md
# Input Edge Capture Unit

This block timestamps the transitions of external input lines. Every capture lane owns a free-running counter that advances on cycles where a tick strobe from the divided timer clock is high. The input passes through a two-flop synchronizer and an optional per-lane inverter, then goes to an edge detector. On a rising edge the lane stores the elapsed tick count and restarts its counter from zero. On a falling edge it stores the count and the counter keeps running. As a result, the falling-edge value is the high time of the input and each rising-edge value after the first is the full period, both in ticks.

Each kind of edge has its own latch flag in the lane control word and its own interrupt status bit. Every status bit has a mask bit. Software reads the values, flags and status through a simple word-addressed register port, and clears flags and status by writing ones to them. The interrupt output is high while any unmasked status bit is set.

Register map, by word address:
- 0: lane enable, with bit n for lane n.
- 1: interrupt mask.
- 2: interrupt status.
- 4+4n: control word of lane n.
- 5+4n: rising-edge value of lane n.
- 6+4n: falling-edge value of lane n.

Unmapped addresses read as zero.

Top module: `edge_capture_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: While a lane's enable bit (address 0, bit n) is 0, that lane detects no edges. Its flags, values and status bits do not change, and its counter is held at zero.
- R3: On a rising edge the lane performs three actions. It stores the counter value plus the current tick into the rising-edge register. It sets the rising flag (control bit 1) and status bit 2n. It restarts its counter from zero.
- R4: On a falling edge the lane stores the counter value plus the current tick into the falling-edge register and sets the falling flag (control bit 2) and status bit 2n+1. The counter is not restarted.
- R5: The counter advances only on cycles where `tick_i` is high, and it wraps modulo 2^CNT_W.
- R6: Control bit 0 inverts the lane input ahead of edge detection, so a physical rising edge is treated as a falling edge.
- R7: Writing 1 clears a flag (control bits 1 and 2) or a status bit (address 2). Writing 0 leaves it unchanged, and a control-word write updates the invert bit without disturbing the flags. When a new edge and a clear arrive in the same cycle, the new edge wins.
- R8: When an edge arrives while its flag is still set, the value register is overwritten with the newer count and the flag stays set.
- R9: `irq_o` is high exactly when some status bit and its mask bit (address 1, same bit position) are both 1.
- R10: An input transition shows up in the flags on the third rising clock edge after the input changes, and not before.
- R11: Lanes are independent. Lane n uses only status and mask bits 2n and 2n+1 and its own three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Counter advance strobe from the divided clock |
| cap_in_i | input | NUM_CH | Asynchronous inputs, one per lane |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on a few properties of the inputs:
- `reg_wr_i` is a single-cycle strobe.
- The tick and register signals are synchronous to the clock.
- Each level on a capture input lasts at least three clock cycles, so the synchronizer never loses a transition.

The stimulus drives every input on the falling clock edge and holds each input level for at least four cycles. It clears flags only after their edges have settled. Expected timestamps are then exact tick counts between edges, and this holds both when the tick is always high and when it runs at half rate.

// File: rtl/cap_pkg.sv
package cap_pkg;

    // Control word bit positions (software-visible).
    localparam int CTRL_INV_BIT   = 0;
    localparam int CTRL_RFLAG_BIT = 1;
    localparam int CTRL_FFLAG_BIT = 2;

    // Word addresses of the global registers and the per-lane block.
    localparam int ADR_CAP_EN   = 0;
    localparam int ADR_IRQ_MASK = 1;
    localparam int ADR_IRQ_STAT = 2;
    localparam int LANE_BASE    = 4;
    localparam int LANE_SHIFT   = 2;   // four words per lane

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CAP_EN,
        RK_IRQ_MASK,
        RK_IRQ_STAT,
        RK_CTRL,
        RK_RISE,
        RK_FALL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] lane;
    } reg_sel_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic reg_sel_t decode_addr(input logic [7:0] addr, input int num_ch);
        reg_sel_t   s;
        logic [7:0] off;
        s.kind = RK_NONE;
        s.lane = '0;
        off    = addr - 8'(LANE_BASE);
        if (int'(addr) == ADR_CAP_EN) begin
            s.kind = RK_CAP_EN;
        end else if (int'(addr) == ADR_IRQ_MASK) begin
            s.kind = RK_IRQ_MASK;
        end else if (int'(addr) == ADR_IRQ_STAT) begin
            s.kind = RK_IRQ_STAT;
        end else if (int'(addr) >= LANE_BASE &&
                     int'(addr) < LANE_BASE + (num_ch << LANE_SHIFT)) begin
            s.lane = off >> LANE_SHIFT;
            case (off[1:0])
                2'd0:    s.kind = RK_CTRL;
                2'd1:    s.kind = RK_RISE;
                2'd2:    s.kind = RK_FALL;
                default: s.kind = RK_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/cap_insync.sv
module cap_insync #(
    parameter int SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic inv_i,
    input  logic din_i,
    output cap_pkg::edge_ev_t ev_o
);
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              lvl;

    assign lvl = sync_q[SYNC_N-1] ^ inv_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], din_i};
            prev_q <= lvl;
        end
    end

    assign ev_o.rise = en_i & lvl & ~prev_q;
    assign ev_o.fall = en_i & ~lvl & prev_q;

endmodule

// File: rtl/cap_lane.sv
module cap_lane #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  cap_pkg::edge_ev_t ev_i,
    input  logic             clr_rise_i,
    input  logic             clr_fall_i,
    output logic [CNT_W-1:0] rise_val_o,
    output logic [CNT_W-1:0] fall_val_o,
    output logic             rise_flag_o,
    output logic             fall_flag_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] stamp;

    // Count including the tick of the current cycle.
    assign stamp = cnt_q + CNT_W'(tick_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (!en_i || ev_i.rise) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rise_val_o  <= '0;
            fall_val_o  <= '0;
            rise_flag_o <= 1'b0;
            fall_flag_o <= 1'b0;
        end else begin
            if (ev_i.rise) begin
                rise_val_o  <= stamp;
                rise_flag_o <= 1'b1;
            end else if (clr_rise_i) begin
                rise_flag_o <= 1'b0;
            end
            if (ev_i.fall) begin
                fall_val_o  <= stamp;
                fall_flag_o <= 1'b1;
            end else if (clr_fall_i) begin
                fall_flag_o <= 1'b0;
            end
        end
    end

    a_r3_cnt_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_i.rise |=> cnt_q == '0);
    a_r3_rise_flag_set: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_i.rise |=> rise_flag_o);
    a_r4_fall_flag_set: assert property (@(posedge clk_i) disable iff (rst_i)
        ev_i.fall |=> fall_flag_o);
    a_r5_cnt_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !ev_i.rise && !tick_i) |=> $stable(cnt_q));
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !clr_rise_i) |=> ($stable(rise_flag_o) && $stable(rise_val_o)));
    a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_flag_o && !clr_rise_i) |=> rise_flag_o);

endmodule

// File: rtl/cap_irq.sv
module cap_irq #(
    parameter int IRQ_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [IRQ_W-1:0] set_i,
    input  logic [IRQ_W-1:0] clr_i,
    input  logic [IRQ_W-1:0] mask_i,
    output logic [IRQ_W-1:0] stat_o,
    output logic             irq_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) stat_o <= '0;
        else       stat_o <= (stat_o & ~clr_i) | set_i;
    end

    assign irq_o = |(stat_o & mask_i);

    a_r7_stat_w1c: assert property (@(posedge clk_i) disable iff (rst_i)
        ((clr_i & ~set_i) != '0) |=> ((stat_o & $past(clr_i & ~set_i)) == '0));
    a_r3_stat_set: assert property (@(posedge clk_i) disable iff (rst_i)
        (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/edge_capture_top.sv
module edge_capture_top #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    parameter int SYNC_N = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic [NUM_CH-1:0] cap_in_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    import cap_pkg::*;

    localparam int IRQ_W = 2 * NUM_CH;

    reg_sel_t          sel;
    logic [NUM_CH-1:0] cap_en_q;
    logic [IRQ_W-1:0]  irq_mask_q;
    logic [IRQ_W-1:0]  irq_set;
    logic [IRQ_W-1:0]  irq_clr;
    logic [IRQ_W-1:0]  irq_stat;
    logic [CNT_W-1:0]  lane_rise [NUM_CH];
    logic [CNT_W-1:0]  lane_fall [NUM_CH];
    logic [DATA_W-1:0] lane_ctrl [NUM_CH];

    assign sel = decode_addr(8'(reg_addr_i), NUM_CH);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap_en_q   <= '0;
            irq_mask_q <= '0;
        end else if (reg_wr_i) begin
            if (sel.kind == RK_CAP_EN)   cap_en_q   <= reg_wdata_i[NUM_CH-1:0];
            if (sel.kind == RK_IRQ_MASK) irq_mask_q <= reg_wdata_i[IRQ_W-1:0];
        end
    end

    assign irq_clr = (reg_wr_i && sel.kind == RK_IRQ_STAT) ? reg_wdata_i[IRQ_W-1:0] : '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic     hit_ctrl;
        logic     inv_q;
        edge_ev_t ev;
        logic     rflag;
        logic     fflag;

        assign hit_ctrl = reg_wr_i && sel.kind == RK_CTRL && sel.lane == 8'(g);

        always_ff @(posedge clk_i) begin
            if (rst_i)         inv_q <= 1'b0;
            else if (hit_ctrl) inv_q <= reg_wdata_i[CTRL_INV_BIT];
        end

        cap_insync #(.SYNC_N(SYNC_N)) u_sync (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .en_i  (cap_en_q[g]),
            .inv_i (inv_q),
            .din_i (cap_in_i[g]),
            .ev_o  (ev)
        );

        cap_lane #(.CNT_W(CNT_W)) u_lane (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .en_i        (cap_en_q[g]),
            .tick_i      (tick_i),
            .ev_i        (ev),
            .clr_rise_i  (hit_ctrl && reg_wdata_i[CTRL_RFLAG_BIT]),
            .clr_fall_i  (hit_ctrl && reg_wdata_i[CTRL_FFLAG_BIT]),
            .rise_val_o  (lane_rise[g]),
            .fall_val_o  (lane_fall[g]),
            .rise_flag_o (rflag),
            .fall_flag_o (fflag)
        );

        assign irq_set[2*g]   = ev.rise;
        assign irq_set[2*g+1] = ev.fall;

        always_comb begin
            lane_ctrl[g]                 = '0;
            lane_ctrl[g][CTRL_INV_BIT]   = inv_q;
            lane_ctrl[g][CTRL_RFLAG_BIT] = rflag;
            lane_ctrl[g][CTRL_FFLAG_BIT] = fflag;
        end
    end

    cap_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .mask_i (irq_mask_q),
        .stat_o (irq_stat),
        .irq_o  (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (sel.kind)
            RK_CAP_EN:   reg_rdata_o = DATA_W'(cap_en_q);
            RK_IRQ_MASK: reg_rdata_o = DATA_W'(irq_mask_q);
            RK_IRQ_STAT: reg_rdata_o = DATA_W'(irq_stat);
            RK_CTRL, RK_RISE, RK_FALL: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (sel.lane == 8'(i)) begin
                        if (sel.kind == RK_CTRL)      reg_rdata_o = lane_ctrl[i];
                        else if (sel.kind == RK_RISE) reg_rdata_o = DATA_W'(lane_rise[i]);
                        else                          reg_rdata_o = DATA_W'(lane_fall[i]);
                    end
                end
            end
            default: reg_rdata_o = '0;
        endcase
    end

    a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_mask_q == '0) |-> !irq_o);

endmodule

// File: tb/sim_edge_capture_top.sv
module sim_edge_capture_top;
    localparam int NUM_CH = 2;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b1;
    logic              half_rate = 1'b0;
    logic [NUM_CH-1:0] cap_in = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        int    addr;
        int    exp;
        string tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #10 clk = ~clk;

    edge_capture_top #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_N(2)
    ) u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .tick_i      (tick),
        .cap_in_i    (cap_in),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    // Tick strobe: always high, or alternating at half rate.
    initial begin
        forever begin
            @(negedge clk);
            tick = half_rate ? ~tick : 1'b1;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic push(input int addr, input int exp, input string tag);
        sb_item_t it;
        it.addr = addr; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic rd(input int addr, output int val);
        reg_addr = ADDR_W'(addr);
        #1;
        val = int'(reg_rdata);
    endtask

    // Monitor side of the scoreboard: pop each expected item and compare.
    task automatic drain();
        sb_item_t it;
        int v;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            @(negedge clk);
            rd(it.addr, v);
            check(it.tag, v, it.exp);
        end
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        reg_addr  = ADDR_W'(addr);
        reg_wdata = DATA_W'(data);
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        cyc(5);
        rst = 1'b0;
        cyc(1);

        // R1: reset state
        for (int a = 0; a < 11; a++) push(a, 0, "R1 reset value");
        drain();
        check("R1 irq after reset", int'(irq), 0);

        // R2: disabled lane ignores its input
        cap_in[0] = 1'b1; cyc(6);
        cap_in[0] = 1'b0; cyc(6);
        push(4, 0, "R2 ctrl while disabled");
        push(2, 0, "R2 status while disabled");
        push(5, 0, "R2 rise value while disabled");
        push(6, 0, "R2 fall value while disabled");
        drain();

        wr(0, 1);
        wr(1, 'hF);

        // R10: synchronizer latency
        cap_in[0] = 1'b1;
        cyc(2); rd(2, v); check("R10 no flag after two edges", v, 0);
        cyc(1); rd(2, v); check("R10 flag on third edge", v, 1);
        check("R9 irq with mask set", int'(irq), 1);

        // R3/R4: high time 10, period 16
        cyc(7); cap_in[0] = 1'b0;
        cyc(6); cap_in[0] = 1'b1;
        cyc(4);
        push(6, 10, "R4 fall value is high time");
        push(5, 16, "R3 rise value is period");
        push(4, 6,  "R3 R4 both flags set");
        push(2, 3,  "R3 R4 status bits");
        drain();

        // R7: write-one-to-clear
        wr(2, 1);
        wr(2, 0);
        wr(4, 2);
        push(2, 2, "R7 status w1c");
        push(4, 4, "R7 ctrl flag w1c");
        drain();

        // R8: overwrite while flag set
        cap_in[0] = 1'b0; cyc(4);
        cap_in[0] = 1'b1; cyc(4);
        cap_in[0] = 1'b0; cyc(4);
        push(6, 4, "R8 fall value overwritten");
        push(4, 6, "R8 flags kept");
        push(2, 3, "R8 status");
        drain();

        // R9: masking
        wr(1, 0);
        check("R9 irq masked off", int'(irq), 0);
        wr(1, 2);
        check("R9 irq via fall bit", int'(irq), 1);
        wr(1, 'hF);

        // R5: half-rate tick
        half_rate = 1'b1;
        cap_in[0] = 1'b1; cyc(8);
        cap_in[0] = 1'b0; cyc(4);
        half_rate = 1'b0;
        push(6, 4, "R5 half-rate tick count");
        drain();

        // R5: counter wraps
        cap_in[0] = 1'b1; cyc(65539);
        cap_in[0] = 1'b0; cyc(4);
        push(6, 3, "R5 counter wrap");
        drain();

        // R6: inversion
        wr(4, 1);
        cyc(4);
        wr(2, 'hF);
        wr(4, 7);
        push(4, 1, "R6 invert set flags clear");
        push(2, 0, "R6 status clear");
        drain();
        cap_in[0] = 1'b1; cyc(4);
        push(4, 5, "R6 physical rise seen as fall");
        push(2, 2, "R6 fall status");
        drain();
        cap_in[0] = 1'b0; cyc(4);
        push(4, 7, "R6 physical fall seen as rise");
        drain();

        // R11: second lane
        wr(2, 'hF);
        wr(0, 3);
        cap_in[1] = 1'b1; cyc(5);
        cap_in[1] = 1'b0; cyc(4);
        push(10, 5,   "R11 lane1 fall value");
        push(8,  6,   "R11 lane1 flags");
        push(2,  'hC, "R11 lane1 status bits");
        push(4,  7,   "R11 lane0 untouched");
        push(0,  3,   "R11 enables");
        drain();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule